// File: doc/BRIEF.md
# Banked Extended Memory Access Port

This block is a byte-wide register window that reaches a battery-backed extended memory through indirect addressing. A host drives a 7-bit register offset with a read or write strobe. A bank bit in the control register at offset 0x0A chooses what the upper half of the offset space (0x40 to 0x7F) shows. In bank 0 that half is plain user RAM. In bank 1 it exposes an extended-control register, a two-byte extended address and a data port.

An access to the data port reads or writes the extended memory at the current extended address. When the burst bit in the extended-control register is set, every data-port access advances the address by one. The address wraps from the last location back to zero. This lets software stream a block with one address setup. A 50-byte user RAM at 0x0E to 0x3F stays visible in both banks.

Top module: `ext_ram_port`

## Requirements
- R1: The control register at offset 0x0A holds the bank select in bit 4. Reads return that bit with all other bits zero. After reset bank 0 is selected.
- R2: Offsets 0x0E through 0x3F address a 50-byte user RAM. It can be read and written regardless of the bank bit.
- R3: With bank 0 selected, offsets 0x40 through 0x7F address a 64-byte user RAM at index offset minus 0x40.
- R4: With bank 1 selected, offset 0x50 reads and writes extended address bits 7:0. Offset 0x51 reads and writes the address bits above bit 7, placed from bit 0 upward. The unimplemented upper bits of 0x51 read as zero.
- R5: With bank 1 selected, offset 0x53 reads or writes the extended memory byte at the current extended address.
- R6: With bank 1 selected, offset 0x4A holds the burst enable in bit 5. Reads return that bit with all other bits zero. Burst is off after reset.
- R7: With burst off, data-port accesses leave the extended address unchanged.
- R8: With burst on, each data-port read or write advances the extended address by one after the access. Back-to-back reads therefore return consecutive bytes.
- R9: An advance from the last extended location (depth minus one) yields address zero.
- R10: Read data appears in the cycle after the read strobe. It holds until the next read strobe.
- R11: These offsets read zero and ignore writes: 0x00 to 0x09, 0x0B to 0x0D, and, in bank 1, every offset in 0x40 to 0x7F other than 0x4A, 0x50, 0x51 and 0x53. Bank-1 accesses never alter the bank-0 RAM, and bank-0 accesses never alter the extended address.
- R12: After reset the extended address is zero and the read data output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_off | input | 7 | Register offset |
| wr_data | input | 8 | Write data |
| rd_stb | input | 1 | Read strobe, one cycle per access |
| wr_stb | input | 1 | Write strobe, one cycle per access; never together with rd_stb |
| rd_data | output | 8 | Read data, valid the cycle after rd_stb |

## Verification
The bench fills the whole extended memory in burst mode. It then expects the address to have wrapped to zero. A design that stops or saturates at the last location reads back a nonzero address.

Directed checks cover the following cases:
- A read at the final location, followed by address readback, catches an off-by-one wrap.
- Two reads on back-to-back strobes catch an increment applied before the access instead of after it.
- Writes to 0x50 and to an unmapped bank-1 offset, each followed by a bank-0 read of the same offset, expose a decode that leaks between banks.
- A write of all ones to the high address register exposes unimplemented bits that are not masked.

Random mixed traffic is then compared against a bench model.

// File: rtl/ext_ram_port_pkg.sv
package ext_ram_port_pkg;

   typedef enum logic [2:0] {
      TGT_NONE,
      TGT_CTRL,
      TGT_URAM_LO,
      TGT_URAM_HI,
      TGT_XCTRL,
      TGT_ALO,
      TGT_AHI,
      TGT_DPORT
   } tgt_e;

   localparam int OFF_W     = 7;
   localparam int BANK_BIT  = 4;
   localparam int BURST_BIT = 5;
   localparam int LO_SIZE   = 50;
   localparam int HI_SIZE   = 64;

   localparam logic [OFF_W-1:0] OFF_CTRL    = 7'h0A;
   localparam logic [OFF_W-1:0] OFF_LO_BASE = 7'h0E;
   localparam logic [OFF_W-1:0] OFF_HI_BASE = 7'h40;
   localparam logic [OFF_W-1:0] OFF_XCTRL   = 7'h4A;
   localparam logic [OFF_W-1:0] OFF_ALO     = 7'h50;
   localparam logic [OFF_W-1:0] OFF_AHI     = 7'h51;
   localparam logic [OFF_W-1:0] OFF_DPORT   = 7'h53;

endpackage

// File: rtl/ext_ram_port_decode.sv
module ext_ram_port_decode
   import ext_ram_port_pkg::*;
#(
   parameter int IDX_W = 6
) (
   input  logic [OFF_W-1:0] off,
   input  logic             bank,
   output tgt_e             tgt,
   output logic [IDX_W-1:0] idx
);

   localparam logic [OFF_W-1:0] LO_END = OFF_LO_BASE + OFF_W'(LO_SIZE);

   logic [OFF_W-1:0] rel_lo;
   logic [OFF_W-1:0] rel_hi;

   assign rel_lo = off - OFF_LO_BASE;
   assign rel_hi = off - OFF_HI_BASE;

   always_comb begin
      tgt = TGT_NONE;
      idx = '0;
      if (off == OFF_CTRL) begin
         tgt = TGT_CTRL;
      end else if (off >= OFF_LO_BASE && off < LO_END) begin
         tgt = TGT_URAM_LO;
         idx = rel_lo[IDX_W-1:0];
      end else if (off >= OFF_HI_BASE) begin
         if (!bank) begin
            tgt = TGT_URAM_HI;
            idx = rel_hi[IDX_W-1:0];
         end else begin
            case (off)
               OFF_XCTRL: tgt = TGT_XCTRL;
               OFF_ALO:   tgt = TGT_ALO;
               OFF_AHI:   tgt = TGT_AHI;
               OFF_DPORT: tgt = TGT_DPORT;
               default:   tgt = TGT_NONE;
            endcase
         end
      end
   end

endmodule

// File: rtl/ext_ram_port_mem.sv
module ext_ram_port_mem #(
   parameter int DEPTH = 64,
   parameter int DW    = 8,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic          re,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wd,
   output logic [DW-1:0] q
);

   logic [DW-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[addr] <= wd;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (re) q <= cells[addr];
   end

endmodule

// File: rtl/ext_ram_port_addr.sv
module ext_ram_port_addr #(
   parameter int DEPTH = 2048,
   localparam int AW   = $clog2(DEPTH),
   localparam int HI_W = AW - 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ld_lo,
   input  logic            ld_hi,
   input  logic [7:0]      din_lo,
   input  logic [HI_W-1:0] din_hi,
   input  logic            step,
   output logic [AW-1:0]   addr
);

   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr <= '0;
      end else if (ld_lo) begin
         addr[7:0] <= din_lo;
      end else if (ld_hi) begin
         addr[AW-1:8] <= din_hi;
      end else if (step) begin
         addr <= (addr == LAST) ? '0 : addr + 1'b1;
      end
   end

endmodule

// File: rtl/ext_ram_port.sv
module ext_ram_port
   import ext_ram_port_pkg::*;
#(
   parameter int EXT_DEPTH = 2048
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [6:0] reg_off,
   input  logic [7:0] wr_data,
   input  logic       rd_stb,
   input  logic       wr_stb,
   output logic [7:0] rd_data
);

   localparam int EXT_AW = $clog2(EXT_DEPTH);
   localparam int HI_W   = EXT_AW - 8;
   localparam int IDX_W  = $clog2(HI_SIZE);

   generate
      if (EXT_DEPTH < 512 || EXT_DEPTH > 8192 || (1 << EXT_AW) != EXT_DEPTH) begin : g_bad_depth
         $error("EXT_DEPTH must be a power of two from 512 to 8192");
      end
   endgenerate

   tgt_e             tgt;
   logic [IDX_W-1:0] idx;
   logic             bank_q;
   logic             burst_q;
   logic [EXT_AW-1:0] xaddr;
   logic             acc_dport;
   logic             acc_ahi;
   logic [7:0]       ura_q, urb_q, ext_q;
   tgt_e             sel_q;
   logic [7:0]       regval, regval_q;
   logic [7:0]       hi_rb;

   ext_ram_port_decode #(.IDX_W(IDX_W)) u_dec (
      .off  (reg_off),
      .bank (bank_q),
      .tgt  (tgt),
      .idx  (idx)
   );

   assign acc_dport = (tgt == TGT_DPORT);
   assign acc_ahi   = (tgt == TGT_AHI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q  <= 1'b0;
         burst_q <= 1'b0;
      end else if (wr_stb) begin
         if (tgt == TGT_CTRL)  bank_q  <= wr_data[BANK_BIT];
         if (tgt == TGT_XCTRL) burst_q <= wr_data[BURST_BIT];
      end
   end

   ext_ram_port_addr #(.DEPTH(EXT_DEPTH)) u_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld_lo  (wr_stb && tgt == TGT_ALO),
      .ld_hi  (wr_stb && tgt == TGT_AHI),
      .din_lo (wr_data),
      .din_hi (wr_data[HI_W-1:0]),
      .step   (burst_q && acc_dport && (rd_stb || wr_stb)),
      .addr   (xaddr)
   );

   ext_ram_port_mem #(.DEPTH(LO_SIZE)) u_ura (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_stb && tgt == TGT_URAM_LO),
      .re    (rd_stb && tgt == TGT_URAM_LO),
      .addr  (idx),
      .wd    (wr_data),
      .q     (ura_q)
   );

   ext_ram_port_mem #(.DEPTH(HI_SIZE)) u_urb (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_stb && tgt == TGT_URAM_HI),
      .re    (rd_stb && tgt == TGT_URAM_HI),
      .addr  (idx),
      .wd    (wr_data),
      .q     (urb_q)
   );

   ext_ram_port_mem #(.DEPTH(EXT_DEPTH)) u_ext (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_stb && acc_dport),
      .re    (rd_stb && acc_dport),
      .addr  (xaddr),
      .wd    (wr_data),
      .q     (ext_q)
   );

   generate
      if (HI_W < 8) begin : g_hi_pad
         assign hi_rb = {{(8 - HI_W){1'b0}}, xaddr[EXT_AW-1:8]};
      end else begin : g_hi_full
         assign hi_rb = xaddr[EXT_AW-1:8];
      end
   endgenerate

   always_comb begin
      regval = '0;
      case (tgt)
         TGT_CTRL:  regval[BANK_BIT]  = bank_q;
         TGT_XCTRL: regval[BURST_BIT] = burst_q;
         TGT_ALO:   regval = xaddr[7:0];
         TGT_AHI:   regval = hi_rb;
         default:   regval = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q    <= TGT_NONE;
         regval_q <= '0;
      end else if (rd_stb) begin
         sel_q    <= tgt;
         regval_q <= regval;
      end
   end

   always_comb begin
      case (sel_q)
         TGT_URAM_LO: rd_data = ura_q;
         TGT_URAM_HI: rd_data = urb_q;
         TGT_DPORT:   rd_data = ext_q;
         default:     rd_data = regval_q;
      endcase
   end

endmodule

// File: rtl/ext_ram_port_chk.sv
module ext_ram_port_chk #(
   parameter int XDEPTH = 2048,
   localparam int XAW   = $clog2(XDEPTH),
   localparam int HI_W  = XAW - 8
) (
   input logic           clk,
   input logic           rst_n,
   input logic           rd_stb,
   input logic           wr_stb,
   input logic           bank,
   input logic           burst,
   input logic           acc_dport,
   input logic           acc_ahi,
   input logic [XAW-1:0] xaddr,
   input logic [7:0]     rd_data
);

   localparam logic [XAW-1:0] LAST = XAW'(XDEPTH - 1);

   assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_dport && (rd_stb || wr_stb) && !burst) |=> $stable(xaddr));

   assert_addr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_dport && (rd_stb || wr_stb) && burst && xaddr != LAST)
      |=> xaddr == XAW'($past(xaddr) + 1'b1));

   assert_addr_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_dport && (rd_stb || wr_stb) && burst && xaddr == LAST) |=> xaddr == '0);

   assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> $stable(rd_data));

   assert_hi_pad_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && acc_ahi) |=> (rd_data >> HI_W) == 8'h00);

   assert_bank0_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!bank && wr_stb) |=> $stable(xaddr));

endmodule

bind ext_ram_port ext_ram_port_chk #(.XDEPTH(EXT_DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_stb    (rd_stb),
   .wr_stb    (wr_stb),
   .bank      (bank_q),
   .burst     (burst_q),
   .acc_dport (acc_dport),
   .acc_ahi   (acc_ahi),
   .xaddr     (xaddr),
   .rd_data   (rd_data)
);

// File: tb/ext_ram_port_test.sv
`timescale 1ns/1ps
module ext_ram_port_test;

   localparam int DEPTH = 2048;
   localparam int AW    = $clog2(DEPTH);

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] reg_off = '0;
   logic [7:0] wr_data = '0;
   logic       rd_stb = 1'b0;
   logic       wr_stb = 1'b0;
   logic [7:0] rd_data;

   int nchk = 0;
   int nerr = 0;

   logic [7:0]    m_ura [50];
   logic [7:0]    m_urb [64];
   logic [7:0]    m_ext [DEPTH];
   logic          m_bank = 1'b0;
   logic          m_burst = 1'b0;
   logic [AW-1:0] m_addr = '0;

   ext_ram_port #(.EXT_DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .reg_off(reg_off), .wr_data(wr_data),
      .rd_stb(rd_stb), .wr_stb(wr_stb), .rd_data(rd_data)
   );

   always #2.5 clk = ~clk;

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      nchk++;
      if (got !== exp) begin
         nerr++;
         $display("FAIL %s: got %02h expected %02h", tag, got, exp);
      end
   endtask

   function automatic logic [7:0] exp_of(input logic [6:0] off);
      if (off == 7'h0A) return {3'b000, m_bank, 4'b0000};
      if (off >= 7'h0E && off < 7'h40) return m_ura[int'(off) - 14];
      if (off >= 7'h40) begin
         if (!m_bank) return m_urb[int'(off) - 64];
         case (off)
            7'h4A:   return {2'b00, m_burst, 5'b00000};
            7'h50:   return m_addr[7:0];
            7'h51:   return 8'(m_addr >> 8);
            7'h53:   return m_ext[m_addr];
            default: return 8'h00;
         endcase
      end
      return 8'h00;
   endfunction

   task automatic model_access(input logic [6:0] off, input logic is_wr, input logic [7:0] d);
      if (is_wr) begin
         if (off == 7'h0A) m_bank = d[4];
         else if (off >= 7'h0E && off < 7'h40) m_ura[int'(off) - 14] = d;
         else if (off >= 7'h40 && !m_bank) m_urb[int'(off) - 64] = d;
         else if (off >= 7'h40) begin
            case (off)
               7'h4A: m_burst = d[5];
               7'h50: m_addr[7:0] = d;
               7'h51: m_addr[AW-1:8] = d[AW-9:0];
               7'h53: m_ext[m_addr] = d;
               default: ;
            endcase
         end
      end
      if (m_bank && off == 7'h53 && m_burst) m_addr = m_addr + 1'b1;
   endtask

   task automatic bus_wr(input logic [6:0] off, input logic [7:0] d);
      @(negedge clk);
      reg_off = off; wr_data = d; wr_stb = 1'b1;
      @(negedge clk);
      wr_stb = 1'b0;
      model_access(off, 1'b1, d);
   endtask

   task automatic bus_rd(input logic [6:0] off, input string tag);
      logic [7:0] e;
      e = exp_of(off);
      @(negedge clk);
      reg_off = off; rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
      chk(tag, rd_data, e);
      model_access(off, 1'b0, 8'h00);
   endtask

   task automatic set_addr(input int a);
      bus_wr(7'h50, 8'(a));
      bus_wr(7'h51, 8'(a >> 8));
   endtask

   initial begin
      #(5.0 * 150000);
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      logic [7:0] d0, d1;
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      chk("R12 rd_data in reset", rd_data, 8'h00);
      rst_n = 1'b1;

      bus_rd(7'h0A, "R1 bank after reset");
      bus_rd(7'h00, "R11 unmapped 0x00");
      bus_wr(7'h0A, 8'h10);
      bus_rd(7'h50, "R12 addr lo after reset");
      bus_rd(7'h51, "R12 addr hi after reset");
      bus_rd(7'h4A, "R6 burst after reset");
      bus_wr(7'h0A, 8'h00);

      for (int i = 0; i < 50; i++) bus_wr(7'(14 + i), 8'($urandom));
      for (int i = 0; i < 64; i++) bus_wr(7'(64 + i), 8'($urandom));
      bus_wr(7'h0A, 8'h10);
      bus_wr(7'h4A, 8'h20);
      for (int i = 0; i < DEPTH; i++) bus_wr(7'h53, 8'($urandom));
      bus_rd(7'h50, "R9 addr lo after full burst fill");
      bus_rd(7'h51, "R9 addr hi after full burst fill");

      set_addr(12'h123);
      for (int i = 0; i < 16; i++) bus_wr(7'h53, 8'(8'hA0 + i));
      set_addr(12'h123);
      for (int i = 0; i < 16; i++) bus_rd(7'h53, "R8 burst readback");
      bus_rd(7'h50, "R8 addr lo after burst");

      bus_wr(7'h4A, 8'h00);
      set_addr(12'h125);
      for (int i = 0; i < 3; i++) bus_rd(7'h53, "R7 repeated read no burst");
      bus_wr(7'h53, 8'h5C);
      bus_rd(7'h53, "R5 write then read no burst");
      bus_rd(7'h50, "R7 addr lo held");

      bus_wr(7'h4A, 8'h20);
      set_addr(12'h200);
      @(negedge clk);
      reg_off = 7'h53; rd_stb = 1'b1;
      @(negedge clk);
      d0 = rd_data;
      @(negedge clk);
      rd_stb = 1'b0;
      d1 = rd_data;
      chk("R10 first back-to-back read", d0, m_ext[12'h200]);
      chk("R8 second back-to-back read", d1, m_ext[12'h201]);
      m_addr = 11'h202;
      bus_rd(7'h50, "R8 addr after two reads");
      repeat (3) @(negedge clk);
      bus_wr(7'h53, 8'h77);
      chk("R10 read data held", rd_data, 8'h02);

      set_addr(DEPTH - 1);
      bus_rd(7'h53, "R5 last location read");
      bus_rd(7'h50, "R9 wrap lo");
      bus_rd(7'h51, "R9 wrap hi");

      bus_wr(7'h51, 8'hFF);
      bus_rd(7'h51, "R4 hi register masking");
      bus_wr(7'h0A, 8'hFF);
      bus_rd(7'h0A, "R1 ctrl other bits zero");
      bus_wr(7'h4A, 8'hFF);
      bus_rd(7'h4A, "R6 xctrl other bits zero");

      bus_wr(7'h50, 8'h3C);
      bus_wr(7'h45, 8'hEE);
      bus_rd(7'h45, "R11 unmapped bank1 offset");
      bus_rd(7'h20, "R2 low RAM in bank 1");
      bus_wr(7'h0A, 8'h00);
      bus_rd(7'h50, "R11 bank0 RAM untouched at 0x50");
      bus_rd(7'h45, "R11 bank0 RAM untouched at 0x45");
      bus_wr(7'h50, 8'h99);
      bus_rd(7'h50, "R3 bank0 RAM at 0x50");
      bus_rd(7'h7F, "R3 bank0 RAM top");
      bus_wr(7'h0A, 8'h10);
      bus_rd(7'h50, "R11 addr unchanged by bank0 write");
      bus_wr(7'h05, 8'hAB);
      bus_rd(7'h05, "R11 unmapped clock offset");
      bus_rd(7'h0C, "R11 unmapped 0x0C");

      for (int n = 0; n < 800; n++) begin
         logic [6:0] off;
         int sel;
         sel = int'($urandom_range(0, 9));
         case (sel)
            0:       off = 7'h0A;
            1, 2, 3: off = 7'(14 + $urandom_range(0, 49));
            4, 5:    off = 7'(64 + $urandom_range(0, 63));
            6, 9:    off = 7'h53;
            7:       off = ($urandom_range(0, 1) == 0) ? 7'h50 : 7'h51;
            default: off = 7'h4A;
         endcase
         if ($urandom_range(0, 1) == 0) bus_wr(off, 8'($urandom));
         else bus_rd(off, "R5 random mixed traffic");
      end

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule